// File: doc/BRIEF.md
# E3 Receive Error Counter

This block accumulates per-frame receive error events for an E3 stream carrying a G.832-style overhead. On every end-of-frame strobe it takes a framing-error flag, the locally computed and the received BIP-8 byte, and a remote-error-indication count. It adds the qualified events to three saturating 16-bit counters: framing, parity and remote error.

A latch strobe copies every counter into its own holding register and restarts the counter from zero. No event is lost, even when the strobe lands on an end-of-frame cycle.

Two control inputs shape the counting. The parity mode input selects one count per errored frame or one count per mismatched bit. The gate-override input turns off the suppression of counts during and just after out-of-frame or AIS alarms. Frame alignment, BIP-8 generation, alarm detection and register decoding sit outside the block.

Top module: `e3_err_count`

## Requirements
- R1: After a synchronous active-low reset, all three counters and all three holding registers read 0.
- R2: Error inputs have no effect except in a cycle where `eof` is 1. Each such cycle is one frame update.
- R3: When `eof` and `frm_err` are both 1 and counting is not gated, the framing counter rises by 1.
- R4: With `par_bitmode` = 0, a frame whose `bip_rx` differs from `bip_calc` in any bit adds exactly 1 to the parity counter. A frame with equal bytes adds 0.
- R5: With `par_bitmode` = 1, the parity counter rises by the number of differing bit positions between `bip_rx` and `bip_calc`, from 0 to 8.
- R6: The remote-error counter rises by the value of `rei_cnt` at each ungated frame.
- R7: With `gate_ovr` = 0 and `oof` or `ais` at 1 in the `eof` cycle, none of the three counters changes.
- R8: With `gate_ovr` = 0, parity and remote-error events are dropped in the frame during which the OR of `oof` and `ais` falls, and in the frame after it. This holds whether the fall coincides with `eof` or not. Framing errors in those frames are still counted.
- R9: With `gate_ovr` = 1, all three error types are counted regardless of `oof`, `ais` or the post-alarm window.
- R10: Each counter stops at 0xFFFF and never wraps.
- R11: On a `latch` cycle, each holding register takes the counter value plus that cycle's increment, saturated, and the counter restarts from 0.
- R12: Holding registers change only on a `latch` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eof | input | 1 | End-of-frame strobe; error inputs are taken in this cycle |
| frm_err | input | 1 | Framing error seen in the ending frame |
| bip_calc | input | 8 | BIP-8 computed over the previous frame |
| bip_rx | input | 8 | BIP-8 byte received in the ending frame |
| rei_cnt | input | 4 | Remote error indications carried by the ending frame |
| oof | input | 1 | Out-of-frame alarm |
| ais | input | 1 | AIS alarm |
| par_bitmode | input | 1 | 0: one parity count per errored frame; 1: one per errored bit |
| gate_ovr | input | 1 | 0: alarm gating active; 1: count regardless of alarms |
| latch | input | 1 | Copy counters to holding registers and clear counters |
| frm_hold | output | 16 | Latched framing error count |
| par_hold | output | 16 | Latched parity error count |
| rei_hold | output | 16 | Latched remote error count |

## Verification
The latch strobe and a frame update can fall in the same cycle. The same is true of an alarm release and a frame update. The bench drives a frame with `latch` held high and expects the holding registers to include that frame's increment, followed by a zero hold at the next bare latch. It also releases AIS exactly on the `eof` cycle and expects that frame and the next to be blanked for parity and remote errors while the framing error still counts. A behavioural model tracks every clock and compares all three holding registers each cycle.

// File: rtl/e3ec_pkg.sv
// Package: shared constants and helpers for the E3 error counter.
// Assumes counters are indexed frame/parity/remote in that fixed order.
package e3ec_pkg;

    localparam int NUM_CTR = 3;

    typedef enum int {
        IDX_FRM = 0,
        IDX_PAR = 1,
        IDX_REI = 2
    } ctr_idx_e;

    // Width needed to hold a count from 0 to n inclusive.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/e3ec_gate.sv
// Alarm gating: decides per frame whether framing events and whether
// parity/remote events may be counted. Tracks a post-alarm blanking
// window measured in end-of-frame strobes.
// Assumes oof/ais are synchronous to clk.
module e3ec_gate #(
    parameter int BLANK_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eof,
    input  logic oof,
    input  logic ais,
    input  logic gate_ovr,
    output logic frm_ok,
    output logic rest_ok
);
    localparam int WIN_W = e3ec_pkg::cnt_width(BLANK_FRAMES);
    localparam logic [WIN_W-1:0] WIN_FULL = WIN_W'(BLANK_FRAMES);
    localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);

    logic             alarm;
    logic             alarm_q;
    logic             alarm_fall;
    logic             blank;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_d;

    // Combine alarms and spot their release.
    always_comb begin
        alarm      = oof | ais;
        alarm_fall = alarm_q & ~alarm;
        blank      = alarm_fall | (win_q != '0);
    end

    // Next value of the blanking window counter.
    always_comb begin
        win_d = win_q;
        if (alarm) begin
            win_d = '0;
        end else if (alarm_fall) begin
            win_d = eof ? (WIN_FULL - WIN_ONE) : WIN_FULL;
        end else if (eof && (win_q != '0)) begin
            win_d = win_q - WIN_ONE;
        end
    end

    // Register alarm history and window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
            win_q   <= '0;
        end else begin
            alarm_q <= alarm;
            win_q   <= win_d;
        end
    end

    // Qualifiers handed to the event stage.
    always_comb begin
        frm_ok  = gate_ovr | ~alarm;
        rest_ok = gate_ovr | (~alarm & ~blank);
    end

endmodule

// File: rtl/e3ec_event.sv
// Event stage: turns one frame's raw error inputs into per-counter
// increments. All increments are zero outside the eof cycle.
// Assumes INC_W is wide enough for both a BIP popcount and rei_cnt.
module e3ec_event #(
    parameter int BIP_W = 8,
    parameter int REI_W = 4,
    parameter int INC_W = 4
) (
    input  logic                                       eof,
    input  logic                                       frm_err,
    input  logic [BIP_W-1:0]                           bip_calc,
    input  logic [BIP_W-1:0]                           bip_rx,
    input  logic [REI_W-1:0]                           rei_cnt,
    input  logic                                       bit_mode,
    input  logic                                       frm_ok,
    input  logic                                       rest_ok,
    output logic [e3ec_pkg::NUM_CTR-1:0][INC_W-1:0]    inc
);
    import e3ec_pkg::*;

    logic [BIP_W-1:0] diff;
    logic [INC_W-1:0] ones;
    logic [INC_W-1:0] par_amt;

    // Count mismatched BIP positions.
    always_comb begin
        diff = bip_calc ^ bip_rx;
        ones = '0;
        for (int b = 0; b < BIP_W; b++) begin
            ones = ones + INC_W'(diff[b]);
        end
    end

    // Parity amount per selected mode.
    always_comb begin
        if (bit_mode) begin
            par_amt = ones;
        end else begin
            par_amt = INC_W'(|diff);
        end
    end

    // Qualified increments for each counter.
    always_comb begin
        inc          = '0;
        inc[IDX_FRM] = INC_W'(eof & frm_ok & frm_err);
        if (eof && rest_ok) begin
            inc[IDX_PAR] = par_amt;
            inc[IDX_REI] = INC_W'(rei_cnt);
        end
    end

endmodule

// File: rtl/e3ec_satctr.sv
// One saturating error counter with a holding register. On latch the
// hold takes the counter plus the current increment, and the counter
// restarts from zero. Assumes INC_W <= CNT_W.
module e3ec_satctr #(
    parameter int CNT_W = 16,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             latch,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] hold
);
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat;

    // Add with saturation at all ones.
    always_comb begin
        sum = {1'b0, cnt} + (CNT_W + 1)'(inc);
        sat = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end

    // Update counter and holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            hold <= '0;
        end else if (latch) begin
            cnt  <= '0;
            hold <= sat;
        end else begin
            cnt  <= sat;
        end
    end

endmodule

// File: rtl/e3_err_count.sv
// E3 receive error counter top: gating, event decode, and three
// saturating counters with holding registers.
// Assumes all inputs synchronous to clk; one eof pulse per frame.
module e3_err_count #(
    parameter int CNT_W        = 16,
    parameter int BIP_W        = 8,
    parameter int REI_W        = 4,
    parameter int BLANK_FRAMES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eof,
    input  logic             frm_err,
    input  logic [BIP_W-1:0] bip_calc,
    input  logic [BIP_W-1:0] bip_rx,
    input  logic [REI_W-1:0] rei_cnt,
    input  logic             oof,
    input  logic             ais,
    input  logic             par_bitmode,
    input  logic             gate_ovr,
    input  logic             latch,
    output logic [CNT_W-1:0] frm_hold,
    output logic [CNT_W-1:0] par_hold,
    output logic [CNT_W-1:0] rei_hold
);
    import e3ec_pkg::*;

    localparam int INC_W = imax(cnt_width(BIP_W), REI_W);

    logic                              frm_ok;
    logic                              rest_ok;
    logic [NUM_CTR-1:0][INC_W-1:0]     inc;
    logic [NUM_CTR-1:0][CNT_W-1:0]     ctr_val;
    logic [NUM_CTR-1:0][CNT_W-1:0]     hold_val;

    e3ec_gate #(
        .BLANK_FRAMES(BLANK_FRAMES)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .eof      (eof),
        .oof      (oof),
        .ais      (ais),
        .gate_ovr (gate_ovr),
        .frm_ok   (frm_ok),
        .rest_ok  (rest_ok)
    );

    e3ec_event #(
        .BIP_W (BIP_W),
        .REI_W (REI_W),
        .INC_W (INC_W)
    ) u_event (
        .eof      (eof),
        .frm_err  (frm_err),
        .bip_calc (bip_calc),
        .bip_rx   (bip_rx),
        .rei_cnt  (rei_cnt),
        .bit_mode (par_bitmode),
        .frm_ok   (frm_ok),
        .rest_ok  (rest_ok),
        .inc      (inc)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        e3ec_satctr #(
            .CNT_W (CNT_W),
            .INC_W (INC_W)
        ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[g]),
            .latch (latch),
            .cnt   (ctr_val[g]),
            .hold  (hold_val[g])
        );
    end

    // Route holding registers to ports.
    always_comb begin
        frm_hold = hold_val[IDX_FRM];
        par_hold = hold_val[IDX_PAR];
        rei_hold = hold_val[IDX_REI];
    end

endmodule

// File: rtl/e3ec_chk.sv
// Checker for e3_err_count: temporal properties on counters and holds.
// Bound into every instance of the top module.
module e3ec_chk #(
    parameter int CNT_W = 16
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     eof,
    input logic                                     oof,
    input logic                                     ais,
    input logic                                     gate_ovr,
    input logic                                     par_bitmode,
    input logic                                     latch,
    input logic [e3ec_pkg::NUM_CTR-1:0][CNT_W-1:0]  ctr_val,
    input logic [CNT_W-1:0]                         frm_hold,
    input logic [CNT_W-1:0]                         par_hold,
    input logic [CNT_W-1:0]                         rei_hold
);
    // R2
    idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eof && !latch) |=> (ctr_val == $past(ctr_val)));

    // R12
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> ($stable(frm_hold) && $stable(par_hold) && $stable(rei_hold)));

    // R11
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (ctr_val == '0));

    // R4
    block_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && !par_bitmode && !latch) |=> (ctr_val[1] <= $past(ctr_val[1]) + 1));

    // R7
    alarm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && (oof || ais) && !gate_ovr && !latch) |=> (ctr_val == $past(ctr_val)));

    // R10
    frm_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> (ctr_val[0] >= $past(ctr_val[0])));

    // R10
    par_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> (ctr_val[1] >= $past(ctr_val[1])));

    // R10
    rei_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> (ctr_val[2] >= $past(ctr_val[2])));

endmodule

bind e3_err_count e3ec_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eof         (eof),
    .oof         (oof),
    .ais         (ais),
    .gate_ovr    (gate_ovr),
    .par_bitmode (par_bitmode),
    .latch       (latch),
    .ctr_val     (ctr_val),
    .frm_hold    (frm_hold),
    .par_hold    (par_hold),
    .rei_hold    (rei_hold)
);

// File: tb/e3_err_count_tb.sv
// Bench: directed stimulus, a behavioural per-clock reference model,
// and hand-computed checks at the holding registers.
module e3_err_count_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eof = 1'b0;
    logic        frm_err = 1'b0;
    logic [7:0]  bip_calc = '0;
    logic [7:0]  bip_rx = '0;
    logic [3:0]  rei_cnt = '0;
    logic        oof = 1'b0;
    logic        ais = 1'b0;
    logic        par_bitmode = 1'b0;
    logic        gate_ovr = 1'b0;
    logic        latch = 1'b0;
    logic [15:0] frm_hold;
    logic [15:0] par_hold;
    logic [15:0] rei_hold;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state.
    int m_cnt[3];
    int m_hold[3];
    int m_win;
    bit m_prev;

    always #10 clk = ~clk;

    e3_err_count u_dut (
        .clk(clk), .rst_n(rst_n), .eof(eof), .frm_err(frm_err),
        .bip_calc(bip_calc), .bip_rx(bip_rx), .rei_cnt(rei_cnt),
        .oof(oof), .ais(ais), .par_bitmode(par_bitmode), .gate_ovr(gate_ovr),
        .latch(latch), .frm_hold(frm_hold), .par_hold(par_hold), .rei_hold(rei_hold)
    );

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 0;
                m_hold[i] = 0;
            end
            m_win = 0;
            m_prev = 0;
        end else begin
            bit al, fall, blk;
            int add[3];
            al = oof || ais;
            fall = m_prev && !al;
            blk = fall || (m_win > 0);
            add[0] = 0; add[1] = 0; add[2] = 0;
            if (eof) begin
                if (gate_ovr || !al) add[0] = frm_err ? 1 : 0;
                if (gate_ovr || (!al && !blk)) begin
                    add[1] = par_bitmode ? $countones(bip_calc ^ bip_rx)
                                         : ((bip_calc != bip_rx) ? 1 : 0);
                    add[2] = rei_cnt;
                end
            end
            if (al) m_win = 0;
            else if (fall) m_win = eof ? 1 : 2;
            else if (eof && m_win > 0) m_win = m_win - 1;
            m_prev = al;
            for (int i = 0; i < 3; i++) begin
                int s;
                s = m_cnt[i] + add[i];
                if (s > 65535) s = 65535;
                if (latch) begin
                    m_hold[i] = s;
                    m_cnt[i] = 0;
                end else begin
                    m_cnt[i] = s;
                end
            end
        end
    end

    // Per-clock comparison of the holding registers against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (frm_hold !== 16'(m_hold[0]) || par_hold !== 16'(m_hold[1]) ||
                rei_hold !== 16'(m_hold[2])) begin
                fails++;
                $display("FAIL model R12: got %h/%h/%h expected %h/%h/%h",
                         frm_hold, par_hold, rei_hold, m_hold[0], m_hold[1], m_hold[2]);
            end
        end
    end

    task automatic check(input string tag, input [15:0] got, input [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check3(input string tag, input [15:0] f, input [15:0] p, input [15:0] r);
        check({tag, " frm"}, frm_hold, f);
        check({tag, " par"}, par_hold, p);
        check({tag, " rei"}, rei_hold, r);
    endtask

    task automatic frame(input bit fe, input [7:0] c, input [7:0] r, input [3:0] re,
                         input bit o, input bit a, input bit lt);
        @(negedge clk);
        eof = 1; frm_err = fe; bip_calc = c; bip_rx = r; rei_cnt = re;
        oof = o; ais = a; latch = lt;
        @(negedge clk);
        eof = 0; frm_err = 0; bip_calc = 0; bip_rx = 0; rei_cnt = 0; latch = 0;
    endtask

    task automatic idle(input bit o, input bit a);
        @(negedge clk);
        eof = 0; oof = o; ais = a; latch = 0;
    endtask

    task automatic do_latch();
        @(negedge clk);
        latch = 1;
        @(negedge clk);
        latch = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    // Directed sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check3("R1", 0, 0, 0);

        // R2 error inputs without eof are ignored
        @(negedge clk);
        frm_err = 1; bip_calc = 8'h00; bip_rx = 8'hFF; rei_cnt = 4'd5;
        repeat (4) @(negedge clk);
        frm_err = 0; bip_calc = 0; bip_rx = 0; rei_cnt = 0;
        do_latch();
        check3("R2", 0, 0, 0);

        // R3 R4 R6 block parity mode
        frame(1, 8'h00, 8'hFF, 4'd3, 0, 0, 0);
        frame(0, 8'h0F, 8'h0F, 4'd0, 0, 0, 0);
        frame(1, 8'h01, 8'h00, 4'd2, 0, 0, 0);
        do_latch();
        check("R3", frm_hold, 16'd2);
        check("R4", par_hold, 16'd2);
        check("R6", rei_hold, 16'd5);

        // R12 holds stay while frames arrive without latch
        frame(1, 8'h00, 8'h80, 4'd7, 0, 0, 0);
        frame(1, 8'h00, 8'h80, 4'd7, 0, 0, 0);
        check3("R12", 2, 2, 5);
        do_latch();
        check3("R12 relatch", 2, 2, 14);

        // R5 bit parity mode
        par_bitmode = 1;
        frame(0, 8'h00, 8'hFF, 4'd0, 0, 0, 0);
        frame(0, 8'h03, 8'h00, 4'd0, 0, 0, 0);
        do_latch();
        check3("R5", 0, 10, 0);
        par_bitmode = 0;

        // R7 R8 alarm gating with release between frames
        frame(1, 8'h00, 8'hFF, 4'd4, 1, 0, 0);
        idle(0, 0);
        frame(1, 8'h00, 8'hFF, 4'd4, 0, 0, 0);
        frame(1, 8'h00, 8'hFF, 4'd4, 0, 0, 0);
        frame(1, 8'h00, 8'hFF, 4'd4, 0, 0, 0);
        do_latch();
        check("R7 R8 frm", frm_hold, 16'd3);
        check("R8 par", par_hold, 16'd1);
        check("R8 rei", rei_hold, 16'd4);

        // R8 release coincident with eof
        idle(0, 1);
        frame(1, 8'h00, 8'hFF, 4'd4, 0, 0, 0);
        frame(1, 8'h00, 8'hFF, 4'd4, 0, 0, 0);
        frame(1, 8'h00, 8'hFF, 4'd4, 0, 0, 0);
        do_latch();
        check3("R8 coincident", 3, 1, 4);

        // R9 gate override counts through alarms
        gate_ovr = 1;
        frame(1, 8'h00, 8'hFF, 4'd4, 1, 0, 0);
        frame(1, 8'h00, 8'hFF, 4'd4, 1, 1, 0);
        idle(0, 0);
        frame(1, 8'h00, 8'hFF, 4'd4, 0, 0, 0);
        do_latch();
        check3("R9", 3, 3, 12);
        gate_ovr = 0;
        frame(0, 8'h00, 8'h00, 4'd0, 0, 0, 0);
        frame(0, 8'h00, 8'h00, 4'd0, 0, 0, 0);

        // R11 latch in the same cycle as a frame update
        frame(1, 8'h00, 8'h10, 4'd1, 0, 0, 0);
        frame(1, 8'h00, 8'h10, 4'd2, 0, 0, 1);
        check3("R11", 2, 2, 3);
        do_latch();
        check3("R11 restart", 0, 0, 0);

        // R10 saturation
        par_bitmode = 1;
        @(negedge clk);
        eof = 1; frm_err = 1; bip_calc = 8'h00; bip_rx = 8'hFF; rei_cnt = 4'd15;
        repeat (8200) @(negedge clk);
        eof = 0; frm_err = 0; bip_rx = 0; rei_cnt = 0;
        do_latch();
        check("R10 frm", frm_hold, 16'd8200);
        check("R10 par", par_hold, 16'hFFFF);
        check("R10 rei", rei_hold, 16'hFFFF);

        @(negedge clk);
        finish_run();
    end

endmodule